// File: doc/BRIEF.md
# Serial Voice Sample Port

This block moves 16-bit linear voice samples between an internal sample stream and an external codec over a four-wire serial link: a bit clock, a frame sync, a data output and a data input. The port can own the link, dividing the system clock down to make the bit clock and producing the frame sync. It can also follow a link owned by another device, in which case both clock and sync arrive as inputs and are resynchronised into the system clock domain.

Each frame contains a programmable number of bit clocks, and the 16-bit sample slot sits at the start of the frame. Two sync shapes are offered. With the single-bit shape, sync is high for one bit period just before the slot. With the slot-wide shape, sync is high for the whole slot. A receive-only burst setting leaves the data output undriven and requests no transmit samples. Outgoing data changes on rising bit-clock edges. Incoming data is captured on falling edges. The data output is released to high impedance once the last slot bit has been sent.

Top module: `pcm_voice_port`

## Requirements
- R1: With `cfg_master`=1 and even divisor D on `cfg_clk_div`, `pcm_clk_o` starts low after reset and toggles every D/2 system clocks. `pcm_clk_oe` and `pcm_sync_oe` are 1 when `cfg_master`=1 and 0 when it is 0.
- R2: The bit position counts 0..L-1 and advances by one on every rising bit-clock event. The first rising event after reset is position 0. L is `cfg_frame_len` clamped to the range 16..256. The slot occupies positions 0..15.
- R3: With the single-bit shape (`cfg_long_sync`=0) in master mode, `pcm_sync_o` is 1 exactly while the position is L-1. It changes on a rising bit-clock event.
- R4: With the slot-wide shape (`cfg_long_sync`=1) in master mode, `pcm_sync_o` is 1 exactly while the position is 0..15.
- R5: `tx_ready` is 1 only in the system cycle whose edge starts position 0. A sample offered with `tx_valid` in that cycle is sent MSB first, with bit 15-p on `pcm_out` during position p.
- R6: `pcm_out_oe` is 1 during positions 0..15. It drops at the rising bit-clock event that closes position 15.
- R7: If `tx_valid` is 0 when a slot starts, zeros are sent in that slot and the sticky `underrun_flag` is set.
- R8: `pcm_in` is captured on falling bit-clock events during positions 0..15, with the first bit as MSB. `rx_valid` rises at the falling event of position 15, carries the word on `rx_data`, and stays high until a cycle with `rx_ready`=1.
- R9: With `cfg_burst`=1, `pcm_out_oe` and `tx_ready` stay 0 and `underrun_flag` is not set. Reception per R8 continues to work.
- R10: In follower mode, `pcm_clk_i`, `pcm_sync_i` and `pcm_in` pass through a two-flop synchroniser. For the single-bit shape, a rising edge at which sync is seen high starts position 0. For the slot-wide shape, the first rising edge at which sync is seen high after being low starts position 1.
- R11: After the first detected sync, a sync that lands at a position other than the expected one realigns the position and sets the sticky `resync_flag`. This flag is never set in master mode.
- R12: While `rst_n` is 0, `pcm_clk_o`, `pcm_sync_o`, `pcm_out_oe`, `rx_valid`, `underrun_flag` and `resync_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: port generates clock and sync; 0: follows external ones |
| cfg_long_sync | input | 1 | 0: single-bit sync; 1: slot-wide sync |
| cfg_burst | input | 1 | Receive-only setting |
| cfg_clk_div | input | 8 | Even system-clock divisor for the master bit clock |
| cfg_frame_len | input | 9 | Bit clocks per frame (clamped 16..256) |
| pcm_clk_i | input | 1 | External bit clock (follower mode) |
| pcm_sync_i | input | 1 | External frame sync (follower mode) |
| pcm_in | input | 1 | Serial data in |
| pcm_clk_o | output | 1 | Generated bit clock |
| pcm_clk_oe | output | 1 | Drive enable for the bit clock pad |
| pcm_sync_o | output | 1 | Generated frame sync |
| pcm_sync_oe | output | 1 | Drive enable for the sync pad |
| pcm_out | output | 1 | Serial data out |
| pcm_out_oe | output | 1 | Drive enable for the data-out pad |
| tx_data | input | 16 | Sample to transmit |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Transmit sample taken this cycle |
| rx_data | output | 16 | Received sample |
| rx_valid | output | 1 | Received sample available |
| rx_ready | input | 1 | Received sample consumed |
| underrun_flag | output | 1 | Sticky: a slot started with no sample |
| resync_flag | output | 1 | Sticky: sync arrived at an unexpected position |

## Verification
The hardest condition to reach is a sync that arrives at the wrong bit position once the follower has already locked. The bench plays the external link owner and drives the clock, sync and data pins itself, one bit period at a time. After several well-formed frames it sends one frame that is 8 bits short. This forces a realignment, and the bench then checks the resync flag and the words received after it. The 16-bit clamp on the frame length and the underrun path are reached by programming a length of 8 and by withholding one particular sample while a behavioural model of the master timing is compared on every cycle.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {SYNC_PULSE = 1'b0, SYNC_SLOT = 1'b1} sync_shape_e;
  typedef struct packed {
    logic din;
    logic sync;
    logic bclk;
  } pin_trio_t;
endpackage

// File: rtl/pcm_bclk_src.sv
module pcm_bclk_src
  import pcm_port_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             ext_clk,
  input  logic             ext_sync,
  input  logic             ext_din,
  input  logic             pin_din,
  output logic             bclk_o,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             sync_s,
  output logic             din_smp
);
  localparam int HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] half, half_lim, cnt_q, cnt_d;
  logic              bclk_q, bclk_d, wrap;
  pin_trio_t         stg_q [SYNC_STAGES];
  pin_trio_t         pins_s;
  logic              clk_prev_q;

  // master divider: half period of cfg_div/2 system clocks
  assign half     = cfg_div[DIV_W-1:1];
  assign half_lim = (half == '0) ? '0 : half - 1'b1;
  assign wrap     = (cnt_q == half_lim);

  always_comb begin
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!master) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  // follower synchroniser chain
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= '0;
          else        stg_q[i] <= '{din: ext_din, sync: ext_sync, bclk: ext_clk};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= '0;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign pins_s = stg_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b0;
    else        clk_prev_q <= pins_s.bclk;
  end

  assign rise_evt = master ? (wrap && !bclk_q) : (pins_s.bclk && !clk_prev_q);
  assign fall_evt = master ? (wrap && bclk_q)  : (!pins_s.bclk && clk_prev_q);
  assign sync_s   = pins_s.sync;
  assign din_smp  = master ? pin_din : pins_s.din;
  assign bclk_o   = bclk_q;

  assert_bclk_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && master && $past(master) && !$past(rise_evt) && !$past(fall_evt))
      |-> $stable(bclk_o));
  assert_bclk_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && master && $past(master) && $past(rise_evt)) |-> bclk_o);
endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int POS_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  sync_shape_e      shape,
  input  logic [POS_W:0]   cfg_len,
  input  logic             rise_evt,
  input  logic             sync_s,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_next,
  output logic             slot_start,
  output logic             sync_o,
  output logic             resync_flag
);
  localparam logic [POS_W:0]   MAX_LEN   = (POS_W+1)'(1 << POS_W);
  localparam logic [POS_W:0]   MIN_LEN   = (POS_W+1)'(SAMPLE_W);
  localparam logic [POS_W-1:0] SLOT_LAST = POS_W'(SAMPLE_W - 1);

  logic [POS_W:0]   len_eff;
  logic [POS_W-1:0] len_last, pos_inc, det_pos;
  logic             det, mismatch, smp_q, locked_q;
  logic             sync_d, resync_d, locked_d, smp_d;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    if (cfg_len < MIN_LEN)      len_eff = MIN_LEN;
    else if (cfg_len > MAX_LEN) len_eff = MAX_LEN;
    else                        len_eff = cfg_len;
  end
  assign len_last = POS_W'(len_eff - 1'b1);

  assign pos_inc  = (pos_q >= len_last) ? '0 : pos_q + 1'b1;
  assign det      = !master && ((shape == SYNC_PULSE) ? sync_s : (sync_s && !smp_q));
  assign det_pos  = (shape == SYNC_PULSE) ? '0 : POS_W'(1);
  assign pos_next = det ? det_pos : pos_inc;
  assign mismatch = det && locked_q && (pos_inc != det_pos);
  assign slot_start = rise_evt && (pos_next == '0);

  always_comb begin
    pos_d    = pos_q;
    smp_d    = smp_q;
    locked_d = locked_q;
    resync_d = resync_flag;
    sync_d   = sync_o;
    if (rise_evt) begin
      pos_d    = pos_next;
      smp_d    = sync_s;
      locked_d = locked_q | det;
      resync_d = resync_flag | mismatch;
      sync_d   = master && ((shape == SYNC_SLOT) ? (pos_next <= SLOT_LAST)
                                                 : (pos_next == len_last));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= '1;
      smp_q       <= 1'b0;
      locked_q    <= 1'b0;
      resync_flag <= 1'b0;
      sync_o      <= 1'b0;
    end else begin
      pos_q       <= pos_d;
      smp_q       <= smp_d;
      locked_q    <= locked_d;
      resync_flag <= resync_d;
      sync_o      <= sync_d;
    end
  end

  assert_sync_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(sync_o)) |-> $past(rise_evt));
  assert_master_no_resync_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(master)) |-> (resync_flag == $past(resync_flag)));
  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q <= len_last) || (pos_q == '1));
endmodule

// File: rtl/pcm_serdes.sv
module pcm_serdes #(
  parameter int SAMPLE_W = 16,
  parameter int POS_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                burst,
  input  logic                rise_evt,
  input  logic                fall_evt,
  input  logic                slot_start,
  input  logic [POS_W-1:0]    pos_q,
  input  logic [POS_W-1:0]    pos_next,
  input  logic                din,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                dout,
  output logic                dout_oe,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic                underrun
);
  localparam logic [POS_W-1:0] SLOT_LAST = POS_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d, rx_data_d, rx_word;
  logic                oe_d, und_d, rxv_d, rx_done;

  assign tx_ready = slot_start && !burst;
  assign rx_word  = {rx_sh_q[SAMPLE_W-2:0], din};
  assign rx_done  = fall_evt && (pos_q == SLOT_LAST);

  always_comb begin
    tx_sh_d = tx_sh_q;
    oe_d    = dout_oe;
    und_d   = underrun;
    if (rise_evt) begin
      oe_d = !burst && (pos_next <= SLOT_LAST);
      if (!burst) begin
        if (slot_start) begin
          tx_sh_d = tx_valid ? tx_data : '0;
          und_d   = underrun | !tx_valid;
        end else begin
          tx_sh_d = {tx_sh_q[SAMPLE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    rx_sh_d   = rx_sh_q;
    rx_data_d = rx_data;
    rxv_d     = rx_valid;
    if (rx_ready) rxv_d = 1'b0;
    if (fall_evt && (pos_q <= SLOT_LAST)) rx_sh_d = rx_word;
    if (rx_done) begin
      rx_data_d = rx_word;
      rxv_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q  <= '0;
      dout_oe  <= 1'b0;
      underrun <= 1'b0;
      rx_sh_q  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      tx_sh_q  <= tx_sh_d;
      dout_oe  <= oe_d;
      underrun <= und_d;
      rx_sh_q  <= rx_sh_d;
      rx_data  <= rx_data_d;
      rx_valid <= rxv_d;
    end
  end

  assign dout = tx_sh_q[SAMPLE_W-1];

  assert_burst_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && burst && $past(burst) && $past(rise_evt)) |-> !dout_oe);
  assert_rx_valid_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(rx_valid)) |-> $past(fall_evt));
  assert_oe_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(dout_oe)) |-> $past(rise_evt));
  assert_underrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(underrun)) |-> $past(slot_start && !tx_valid));
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int POS_W       = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic                cfg_long_sync,
  input  logic                cfg_burst,
  input  logic [DIV_W-1:0]    cfg_clk_div,
  input  logic [POS_W:0]      cfg_frame_len,
  input  logic                pcm_clk_i,
  input  logic                pcm_sync_i,
  input  logic                pcm_in,
  output logic                pcm_clk_o,
  output logic                pcm_clk_oe,
  output logic                pcm_sync_o,
  output logic                pcm_sync_oe,
  output logic                pcm_out,
  output logic                pcm_out_oe,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic                underrun_flag,
  output logic                resync_flag
);
  logic             rise_evt, fall_evt, sync_s, din_smp, slot_start;
  logic [POS_W-1:0] pos_q, pos_next;
  sync_shape_e      shape;

  assign shape       = cfg_long_sync ? SYNC_SLOT : SYNC_PULSE;
  assign pcm_clk_oe  = cfg_master;
  assign pcm_sync_oe = cfg_master;

  pcm_bclk_src #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_bclk (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .cfg_div(cfg_clk_div),
    .ext_clk(pcm_clk_i), .ext_sync(pcm_sync_i), .ext_din(pcm_in), .pin_din(pcm_in),
    .bclk_o(pcm_clk_o), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .sync_s(sync_s), .din_smp(din_smp)
  );

  pcm_frame_ctl #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .shape(shape),
    .cfg_len(cfg_frame_len), .rise_evt(rise_evt), .sync_s(sync_s),
    .pos_q(pos_q), .pos_next(pos_next), .slot_start(slot_start),
    .sync_o(pcm_sync_o), .resync_flag(resync_flag)
  );

  pcm_serdes #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_serdes (
    .clk(clk), .rst_n(rst_n), .burst(cfg_burst), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .slot_start(slot_start), .pos_q(pos_q),
    .pos_next(pos_next), .din(din_smp), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .dout(pcm_out), .dout_oe(pcm_out_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .underrun(underrun_flag)
  );
endmodule

// File: tb/pcm_voice_port_tb_top.sv
module pcm_voice_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b1, cfg_long_sync = 1'b0, cfg_burst = 1'b0;
  logic [7:0]  cfg_clk_div = 8'd4;
  logic [8:0]  cfg_frame_len = 9'd32;
  logic        pcm_clk_i = 1'b0, pcm_sync_i = 1'b0, pcm_in;
  logic        pcm_clk_o, pcm_clk_oe, pcm_sync_o, pcm_sync_oe, pcm_out, pcm_out_oe;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid, rx_ready = 1'b0;
  logic        underrun_flag, resync_flag;

  int n_cmp = 0, n_bad = 0, cyc = 0, k = 0;
  int half = 2, len = 32, ufr = -1, frcnt = 0, rx_cnt = 0;
  bit cmp_on = 0, long_m = 0, burst_m = 0;
  logic m_in = 1'b0, s_in = 1'b0;
  logic [15:0] last_tx = '0;
  logic [15:0] rxq[$];

  assign pcm_in = cmp_on ? m_in : s_in;

  always #2 clk = ~clk;

  pcm_voice_port dut_i (.*);

  function automatic logic [15:0] txw(int f);
    return 16'hA5C3 ^ 16'(f * 7993);
  endfunction
  function automatic logic [15:0] rxw(int f);
    return 16'h3C96 ^ 16'(f * 3665);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) k++;
    else k = 0;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // reference model of master timing + sample stream driver, on negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmp_on) begin
        int hk, rises, m, p, fr, k1, m1;
        bit rdy, oe_e, sy_e, ck_e, un_e;
        hk = k / half;
        rises = (hk + 1) / 2;
        m = rises - 1;
        p = (rises > 0) ? (m % len) : -1;
        fr = (rises > 0) ? (m / len) : 0;
        ck_e = (hk % 2) == 1;
        sy_e = (rises > 0) && (long_m ? (p < 16) : (p == len - 1));
        oe_e = (rises > 0) && !burst_m && (p < 16);
        un_e = !burst_m && (ufr >= 0) && (rises > ufr * len);
        k1 = k + 1;
        m1 = (k1 / half - 1) / 2;
        rdy = !burst_m && (k1 % half == 0) && ((k1 / half) % 2 == 1) && (m1 % len == 0);
        chk("R1", "pcm_clk_o", pcm_clk_o, ck_e);
        chk("R1", "pcm_clk_oe", pcm_clk_oe, 1);
        chk(long_m ? "R4" : "R3", "pcm_sync_o", pcm_sync_o, sy_e);
        chk(burst_m ? "R9" : "R6", "pcm_out_oe", pcm_out_oe, oe_e);
        if (oe_e) chk("R5", "pcm_out", pcm_out, ((fr == ufr) ? 16'h0 : txw(fr)) >> (15 - p) & 1);
        chk(burst_m ? "R9" : "R5", "tx_ready", tx_ready, rdy);
        chk("R7", "underrun_flag", underrun_flag, un_e);
        chk("R11", "resync_flag", resync_flag, 0);
        if (rx_valid && !rx_ready) begin
          chk("R8", "rx_data", rx_data, rxw(fr));
          rx_cnt++;
        end
        m_in = (rises > 0 && p < 16) ? rxw(fr)[15 - p] : 1'b0;
      end else if (rx_valid && !rx_ready) begin
        rxq.push_back(rx_data);
      end
      rx_ready = rx_valid && !rx_ready;
      if (tx_ready) begin
        tx_valid = (frcnt != ufr);
        tx_data  = txw(frcnt);
        last_tx  = tx_valid ? tx_data : 16'h0;
        frcnt++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    frcnt = 0; rx_cnt = 0; rx_ready = 1'b0; tx_valid = 1'b0;
    rxq.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_master(int div, int lenp, int model_len, bit lng, bit bst, int u, int ncyc);
    cfg_master = 1'b1; cfg_long_sync = lng; cfg_burst = bst;
    cfg_clk_div = 8'(div); cfg_frame_len = 9'(lenp);
    half = div / 2; len = model_len; long_m = lng; burst_m = bst; ufr = u;
    do_reset();
    cmp_on = 1;
    repeat (ncyc) @(negedge clk);
    cmp_on = 0;
    chk("R8", "received word count >= 3", rx_cnt >= 3, 1);
  endtask

  // follower-mode link owner: one bit period of 8 system clocks
  task automatic ext_bit(input logic sy, input logic d, output logic smp);
    @(negedge clk) pcm_clk_i = 1'b1;
    @(negedge clk) begin pcm_sync_i = sy; s_in = d; end
    repeat (3) @(negedge clk);
    pcm_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    smp = pcm_out;
  endtask

  task automatic send_frame(int nb, int f, bit lng, bit check_tx);
    logic [15:0] got, exp_tx;
    logic b;
    got = '0; exp_tx = '0;
    for (int q = 0; q < nb; q++) begin
      ext_bit(lng ? (q < 16) : (q == nb - 1), (q < 16) ? rxw(f)[15 - q] : 1'b0, b);
      if (q == 0) exp_tx = last_tx;
      if (q < 16) got = {got[14:0], b};
    end
    if (check_tx) chk("R10", $sformatf("follower tx frame %0d", f), got, exp_tx);
  endtask

  initial begin
    logic b;
    // R12: reset state
    cfg_master = 1'b1; cfg_clk_div = 8'd4;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", "pcm_clk_o in reset", pcm_clk_o, 0);
    chk("R12", "pcm_sync_o in reset", pcm_sync_o, 0);
    chk("R12", "pcm_out_oe in reset", pcm_out_oe, 0);
    chk("R12", "rx_valid in reset", rx_valid, 0);
    chk("R12", "flags in reset", {underrun_flag, resync_flag}, 0);

    // master, single-bit sync, withheld sample in frame 2 (R7)
    run_master(4, 32, 32, 0, 0, 2, 1000);
    // master, slot-wide sync, odd half period
    run_master(6, 20, 20, 1, 0, -1, 900);
    // master, receive-only burst, length 8 clamped to 16 (R2)
    run_master(2, 8, 16, 0, 1, -1, 300);

    // follower, single-bit sync with a short frame forcing realignment
    cfg_master = 1'b0; cfg_long_sync = 1'b0; cfg_burst = 1'b0;
    cfg_frame_len = 9'd32; ufr = -1;
    pcm_clk_i = 1'b0; pcm_sync_i = 1'b0; s_in = 1'b0;
    do_reset();
    repeat (4) @(negedge clk);
    chk("R1", "pcm_clk_oe follower", {pcm_clk_oe, pcm_sync_oe}, 0);
    ext_bit(1'b1, 1'b0, b);
    for (int f = 0; f < 3; f++) send_frame(32, f, 0, 1);
    chk("R11", "resync before misplaced sync", resync_flag, 0);
    send_frame(24, 3, 0, 1);
    send_frame(32, 4, 0, 1);
    chk("R11", "resync after misplaced sync", resync_flag, 1);
    send_frame(32, 5, 0, 1);
    repeat (10) @(negedge clk);
    chk("R10", "rx words count", rxq.size() >= 3, 1);
    if (rxq.size() >= 3) begin
      chk("R11", "rx short frame word", rxq[rxq.size()-3], rxw(3));
      chk("R11", "rx realigned word", rxq[rxq.size()-2], rxw(4));
      chk("R10", "rx last word", rxq[rxq.size()-1], rxw(5));
    end

    // follower, slot-wide sync
    cfg_long_sync = 1'b1;
    pcm_clk_i = 1'b0; pcm_sync_i = 1'b0; s_in = 1'b0;
    do_reset();
    for (int i = 0; i < 5; i++) ext_bit(1'b0, 1'b0, b);
    send_frame(32, 0, 1, 0);
    send_frame(32, 1, 1, 1);
    send_frame(32, 2, 1, 1);
    repeat (10) @(negedge clk);
    chk("R10", "slot-wide rx count", rxq.size() >= 2, 1);
    if (rxq.size() >= 2) begin
      chk("R10", "slot-wide rx frame 1", rxq[rxq.size()-2], rxw(1));
      chk("R10", "slot-wide rx frame 2", rxq[rxq.size()-1], rxw(2));
    end
    chk("R11", "no resync on steady slot-wide sync", resync_flag, 0);
    chk("R9", "no underrun with samples supplied", underrun_flag, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule